// File: doc/BRIEF.md
# Memory Controller Event Counter Bank

This block is a bank of ten 32-bit event counters for a memory controller. It is programmed through a simple 32-bit register port with a write strobe and an address. Reads are combinational on the address. Counters 0 to 7 belong to a half-rate group and advance only on cycles where the half-rate enable input is high. Counters 8 and 9 belong to the full-rate group and can advance on every clock. Both groups run on one clock in this model.

Each counter has four settings:
- an event code, which picks one line of its group's event bus or a free-running cycle count;
- a 45-bit mask/match filter, compared against an attribute bus that travels with the events;
- an invert bit, which flips the outcome of the filter;
- an increment mode, which counts either every qualified cycle or only the cycles where the condition rises.

A counter that wraps from all ones to zero sets its bit in its group's overflow status register. A level interrupt stays high while any overflow bit is set. Software stops each counter on its own by clearing its enable bit, reads the value, and may preset it to a start value such as 0x80000000.

Top module: `evt_counter_bank`

## Requirements
- R1: After reset every register reads zero, and `irq` is low.
- R2: Counter n has a register group at byte address 0x10 + 0x28*n. The group holds these registers:
  - +0x0: mask bits 31:0;
  - +0x4: mask bits 44:32, held in data bits 12:0;
  - +0x8: match bits 31:0;
  - +0xC: match bits 44:32, held in data bits 12:0;
  - +0x10: control, bits 8:0;
  - +0x20: value, 32 bits.

  Stored fields read back as written. Data bits above a register's width read as zero.
- R3: Addresses that map to no register read as zero, and writes to them change nothing. These include 0x0, 0x4, group offsets 0x14, 0x18, 0x1C and 0x24, and 0x1A0 and above.
- R4: Control bit 0 is the enable. A counter advances only while the bit is set. Clearing it freezes the value.
- R5: Control bits 6:2 hold the event code. Code 0 counts every tick of the counter's group. In the half-rate group, codes 1 to 25 follow `evt_half[code-1]`. In the full-rate group, codes 1 and 2 follow `evt_full[code-1]`. Any other code never counts.
- R6: The filter passes when `(evt_attr & mask) == (match & mask)` over 45 bits. The high mask and match words cover attribute bits 44:32. A zero mask always passes.
- R7: Control bit 1 inverts the filter result. The selected event must still be high for the counter to count.
- R8: Control bits 8:7 hold the increment mode:
  - mode 1 adds one only on a tick where the qualified condition is high and was low on the previous tick of the group;
  - modes 0, 2 and 3 add one on every qualified tick.
- R9: Counters 0 to 7 change only on clocks where `half_en` is high. Counters 8 and 9 ignore `half_en`.
- R10: A write to a value register loads the written data. When a count falls on the same clock as the write, the write wins.
- R11: A counter that steps from 0xFFFFFFFF to 0 sets an overflow bit:
  - counters 0 to 7 set bit n of the register at address 0x8;
  - counters 8 and 9 set bit n-8 of the register at address 0xC.
- R12: A write to an overflow status register clears the bits written as 0 and keeps the bits written as 1. An overflow on the same clock still sets its bit.
- R13: `irq` is high exactly while any overflow status bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both counter groups |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_en | input | 1 | Tick enable for the half-rate group |
| reg_addr | input | 12 | Byte address for register reads and writes |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_half | input | 25 | Half-rate event lines, for codes 1 to 25 |
| evt_full | input | 2 | Full-rate event lines, for codes 1 and 2 |
| evt_attr | input | 45 | Attribute bus compared by the filters |
| irq | output | 1 | Level interrupt, high while any overflow bit is set |

## Verification
A register write lands on the rising edge that its strobe spans. Read data follows the address with no register in the path, so each read is sampled one time unit after the falling edge that sets the address.

A count, an overflow flag and the interrupt all update on the same rising edge as the qualifying event. The bench therefore drives each event pattern at a falling edge, so that each step covers exactly one rising edge. It returns the inputs to idle before it reads anything.

The edge-sensitive mode and the write-wins case are timed so that the edge being checked falls between two known falling edges.

// File: rtl/ecb_pkg.sv
package ecb_pkg;

  localparam int CTRL_W = 9;

  typedef struct packed {
    logic [1:0] mode;
    logic [4:0] evsel;
    logic       inv;
    logic       en;
  } ctrl_t;

  // Mask/match compare: passes when every masked attribute bit equals the match bit.
  function automatic logic filt_pass(input logic [63:0] attr,
                                     input logic [63:0] mask,
                                     input logic [63:0] match);
    return ((attr ^ match) & mask) == 64'd0;
  endfunction

  // Count step: returns {carry, next value}.
  function automatic logic [32:0] step_count(input logic [31:0] value, input logic inc);
    return {1'b0, value} + {32'd0, inc};
  endfunction

endpackage

// File: rtl/ecb_slice.sv
module ecb_slice
  import ecb_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int GRP_ADDR = 16,
  parameter int NUM_EVT  = 26,
  parameter int ATTR_W   = 45
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [31:0]        reg_wdata,
  input  logic [NUM_EVT-2:0] evt_bus,
  input  logic [ATTR_W-1:0]  evt_attr,
  output logic [31:0]        rd_data,
  output logic               wrap
);

  localparam int HI_W = ATTR_W - 32;
  localparam logic [ADDR_W-1:0] A_MLO = ADDR_W'(GRP_ADDR + 'h00);
  localparam logic [ADDR_W-1:0] A_MHI = ADDR_W'(GRP_ADDR + 'h04);
  localparam logic [ADDR_W-1:0] A_TLO = ADDR_W'(GRP_ADDR + 'h08);
  localparam logic [ADDR_W-1:0] A_THI = ADDR_W'(GRP_ADDR + 'h0C);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(GRP_ADDR + 'h10);
  localparam logic [ADDR_W-1:0] A_VAL = ADDR_W'(GRP_ADDR + 'h20);

  logic [ATTR_W-1:0] mask_q, match_q;
  ctrl_t             ctrl_q;
  logic [31:0]       cnt_q;
  logic              prev_q;

  logic        val_wr;
  logic [31:0] evt_vec;
  logic        evt_raw, filt, qual, inc;
  logic [32:0] stepped;

  assign val_wr  = reg_wr && (reg_addr == A_VAL);
  assign evt_vec = 32'({evt_bus, 1'b1});
  assign evt_raw = (32'(ctrl_q.evsel) < NUM_EVT) ? evt_vec[ctrl_q.evsel] : 1'b0;
  assign filt    = filt_pass(64'(evt_attr), 64'(mask_q), 64'(match_q));
  assign qual    = evt_raw & (filt ^ ctrl_q.inv);
  assign inc     = tick & ctrl_q.en & ((ctrl_q.mode == 2'd1) ? (qual & ~prev_q) : qual);
  assign stepped = step_count(cnt_q, inc);
  assign wrap    = inc & stepped[32];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      match_q <= '0;
      ctrl_q  <= '0;
      cnt_q   <= '0;
      prev_q  <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_MLO) mask_q[31:0]      <= reg_wdata;
      if (reg_wr && reg_addr == A_MHI) mask_q[ATTR_W-1:32] <= reg_wdata[HI_W-1:0];
      if (reg_wr && reg_addr == A_TLO) match_q[31:0]     <= reg_wdata;
      if (reg_wr && reg_addr == A_THI) match_q[ATTR_W-1:32] <= reg_wdata[HI_W-1:0];
      if (reg_wr && reg_addr == A_CTL) ctrl_q            <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
      if (val_wr)                       cnt_q             <= reg_wdata;
      else                              cnt_q             <= stepped[31:0];
      if (tick)                         prev_q            <= qual;
    end
  end

  always_comb begin
    rd_data = '0;
    if      (reg_addr == A_MLO) rd_data = mask_q[31:0];
    else if (reg_addr == A_MHI) rd_data = 32'(mask_q[ATTR_W-1:32]);
    else if (reg_addr == A_TLO) rd_data = match_q[31:0];
    else if (reg_addr == A_THI) rd_data = 32'(match_q[ATTR_W-1:32]);
    else if (reg_addr == A_CTL) rd_data = 32'(ctrl_q);
    else if (reg_addr == A_VAL) rd_data = cnt_q;
  end

  // R4: a disabled counter holds its value
  a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.en && !val_wr) |=> $stable(cnt_q));
  // R9: no tick, no change
  a_r9_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !val_wr) |=> $stable(cnt_q));
  // R10: a value write always lands
  a_r10_preset: assert property (@(posedge clk) disable iff (!rst_n)
    val_wr |=> (cnt_q == $past(reg_wdata)));
  // R11: a wrap leaves the counter at zero
  a_r11_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !val_wr) |=> (cnt_q == 32'd0));
  // R8: in edge mode a condition that was already high adds nothing
  a_r8_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.mode == 2'd1 && prev_q && !val_wr) |=> $stable(cnt_q));

endmodule

// File: rtl/ecb_ovf.sv
module ecb_ovf #(
  parameter int ADDR_W = 12,
  parameter int N      = 8,
  parameter int ADDR   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      wrap,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [N-1:0]      status,
  output logic [31:0]       rd_data
);

  localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(ADDR);

  logic         st_wr;
  logic [N-1:0] kept;

  assign st_wr   = reg_wr && (reg_addr == A_ST);
  assign kept    = st_wr ? (status & reg_wdata[N-1:0]) : status;
  assign rd_data = (reg_addr == A_ST) ? 32'(status) : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= kept | wrap;
  end

  // R11: every wrap reaches its status bit
  a_r11_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap) |=> ((status & $past(wrap)) == $past(wrap)));
  // R12: a status write with no wrap leaves only the bits written as 1
  a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && wrap == '0) |=> (status == ($past(status) & $past(reg_wdata[N-1:0]))));

endmodule

// File: rtl/evt_counter_bank.sv
module evt_counter_bank #(
  parameter int ADDR_W     = 12,
  parameter int NUM_HALF   = 8,
  parameter int NUM_FULL   = 2,
  parameter int HALF_EVTS  = 26,
  parameter int FULL_EVTS  = 3,
  parameter int ATTR_W     = 45,
  parameter int GRP_BASE   = 'h10,
  parameter int GRP_STRIDE = 'h28,
  parameter int ST_HALF_A  = 'h8,
  parameter int ST_FULL_A  = 'hC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 half_en,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [HALF_EVTS-2:0] evt_half,
  input  logic [FULL_EVTS-2:0] evt_full,
  input  logic [ATTR_W-1:0]    evt_attr,
  output logic                 irq
);

  localparam int NUM_CTR = NUM_HALF + NUM_FULL;

  logic [NUM_CTR-1:0]  wrap;
  logic [31:0]         slice_rd [NUM_CTR];
  logic [NUM_HALF-1:0] st_half;
  logic [NUM_FULL-1:0] st_full;
  logic [31:0]         rd_half, rd_full;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    if (i < NUM_HALF) begin : g_half
      ecb_slice #(.ADDR_W(ADDR_W), .GRP_ADDR(GRP_BASE + GRP_STRIDE * i),
                  .NUM_EVT(HALF_EVTS), .ATTR_W(ATTR_W)) u_slice (
        .clk(clk), .rst_n(rst_n), .tick(half_en),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .evt_bus(evt_half), .evt_attr(evt_attr),
        .rd_data(slice_rd[i]), .wrap(wrap[i]));
    end else begin : g_full
      ecb_slice #(.ADDR_W(ADDR_W), .GRP_ADDR(GRP_BASE + GRP_STRIDE * i),
                  .NUM_EVT(FULL_EVTS), .ATTR_W(ATTR_W)) u_slice (
        .clk(clk), .rst_n(rst_n), .tick(1'b1),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .evt_bus(evt_full), .evt_attr(evt_attr),
        .rd_data(slice_rd[i]), .wrap(wrap[i]));
    end
  end

  ecb_ovf #(.ADDR_W(ADDR_W), .N(NUM_HALF), .ADDR(ST_HALF_A)) u_ovf_half (
    .clk(clk), .rst_n(rst_n), .wrap(wrap[NUM_HALF-1:0]),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .status(st_half), .rd_data(rd_half));

  ecb_ovf #(.ADDR_W(ADDR_W), .N(NUM_FULL), .ADDR(ST_FULL_A)) u_ovf_full (
    .clk(clk), .rst_n(rst_n), .wrap(wrap[NUM_CTR-1:NUM_HALF]),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .status(st_full), .rd_data(rd_full));

  always_comb begin
    reg_rdata = rd_half | rd_full;
    for (int i = 0; i < NUM_CTR; i++) reg_rdata = reg_rdata | slice_rd[i];
  end

  assign irq = (|st_half) | (|st_full);

  // R13: an overflow on any counter raises the interrupt on the next cycle
  a_r13_irq_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap) |=> irq);

endmodule

// File: tb/tb_evt_counter_bank.sv
module tb_evt_counter_bank;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        half_en = 1'b1;
  logic [11:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [24:0] evt_half = '0;
  logic [1:0]  evt_full = '0;
  logic [44:0] evt_attr = '0;
  logic        irq;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  evt_counter_bank dut (
    .clk(clk), .rst_n(rst_n), .half_en(half_en),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_half(evt_half), .evt_full(evt_full), .evt_attr(evt_attr), .irq(irq));

  function automatic logic [11:0] grp(input int n, input int off);
    return 12'(16 + 40 * n + off);
  endfunction

  localparam int O_MLO = 'h0, O_MHI = 'h4, O_TLO = 'h8, O_THI = 'hC, O_CTL = 'h10, O_VAL = 'h20;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata, exp, tag);
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk);
    #1;
    chk({31'd0, irq}, {31'd0, exp}, tag);
  endtask

  task automatic apply(input logic [24:0] h, input logic [1:0] f, input logic [44:0] a, input logic he);
    @(negedge clk);
    evt_half = h; evt_full = f; evt_attr = a; half_en = he;
  endtask

  task automatic idle();
    apply('0, '0, '0, 1'b1);
  endtask

  task automatic t_reset();
    rd(grp(0, O_CTL), 32'd0, "R1 ctrl0");
    rd(grp(9, O_VAL), 32'd0, "R1 value9");
    rd(grp(5, O_MHI), 32'd0, "R1 maskhi5");
    rd(12'h8, 32'd0, "R1 half status");
    rd(12'hC, 32'd0, "R1 full status");
    chk_irq(1'b0, "R1 irq");
  endtask

  task automatic t_regmap();
    wr(grp(3, O_MLO), 32'hDEADBEEF);
    wr(grp(3, O_MHI), 32'hFFFFFFFF);
    wr(grp(3, O_TLO), 32'h13579BDF);
    wr(grp(3, O_THI), 32'h0000ABCD);
    wr(grp(3, O_CTL), 32'hFFFFFFFF);
    wr(grp(3, O_VAL), 32'hCAFEF00D);
    rd(grp(3, O_MLO), 32'hDEADBEEF, "R2 mask lo");
    rd(grp(3, O_MHI), 32'h00001FFF, "R2 mask hi width");
    rd(grp(3, O_TLO), 32'h13579BDF, "R2 match lo");
    rd(grp(3, O_THI), 32'h00000BCD, "R2 match hi width");
    rd(grp(3, O_CTL), 32'h000001FF, "R2 ctrl width");
    rd(grp(3, O_VAL), 32'hCAFEF00D, "R2 value");
    wr(grp(3, O_CTL), 0); wr(grp(3, O_MLO), 0); wr(grp(3, O_MHI), 0);
    wr(grp(3, O_TLO), 0); wr(grp(3, O_THI), 0); wr(grp(3, O_VAL), 0);
  endtask

  task automatic t_unmapped();
    wr(grp(0, 'h14), 32'h1234);
    wr(12'h4, 32'hFFFF);
    rd(grp(0, 'h14), 32'd0, "R3 group gap 0x14");
    rd(grp(4, 'h1C), 32'd0, "R3 group gap 0x1C");
    rd(grp(9, 'h24), 32'd0, "R3 group gap 0x24");
    rd(12'h0, 32'd0, "R3 addr 0x0");
    rd(12'h4, 32'd0, "R3 addr 0x4");
    rd(12'h1A0, 32'd0, "R3 past last group");
    rd(grp(0, O_MLO), 32'd0, "R3 no leak into mask");
  endtask

  task automatic t_evtsel();
    wr(grp(1, O_CTL), 32'h15);
    for (int i = 0; i < 6; i++) apply(25'h10, 0, 0, 1);
    for (int i = 0; i < 3; i++) apply(25'h1FFFFEF, 0, 0, 1);
    idle();
    rd(grp(1, O_VAL), 32'd6, "R5 code 5 follows line 4");
    wr(grp(1, O_CTL), 32'h14);
    for (int i = 0; i < 4; i++) apply(25'h10, 0, 0, 1);
    idle();
    rd(grp(1, O_VAL), 32'd6, "R4 disabled freezes");
    wr(grp(1, O_CTL), 32'h6D);
    for (int i = 0; i < 4; i++) apply(25'h1FFFFFF, 0, 0, 1);
    idle();
    rd(grp(1, O_VAL), 32'd6, "R5 half code 27 never counts");
    wr(grp(1, O_CTL), 0);
    wr(grp(9, O_CTL), 32'h9);
    for (int i = 0; i < 4; i++) apply(0, 2'b10, 0, 1);
    for (int i = 0; i < 2; i++) apply(0, 2'b01, 0, 1);
    idle();
    rd(grp(9, O_VAL), 32'd4, "R5 full code 2");
    wr(grp(9, O_CTL), 32'hD);
    for (int i = 0; i < 3; i++) apply(0, 2'b11, 0, 1);
    idle();
    rd(grp(9, O_VAL), 32'd4, "R5 full code 3 never counts");
    wr(grp(9, O_CTL), 0);
    wr(grp(6, O_CTL), 32'h1);
    repeat (3) @(negedge clk);
    wr(grp(6, O_CTL), 0);
    rd(grp(6, O_VAL), 32'd5, "R5 code 0 counts every tick");
  endtask

  task automatic t_filter();
    wr(grp(2, O_MLO), 32'hFF);  wr(grp(2, O_MHI), 32'h1000);
    wr(grp(2, O_TLO), 32'h5A);  wr(grp(2, O_THI), 32'h1000);
    wr(grp(2, O_CTL), 32'h5);
    for (int i = 0; i < 3; i++) apply(1, 0, 45'h1ABCDEF0125A, 1);
    for (int i = 0; i < 2; i++) apply(1, 0, 45'h0ABCDEF0125A, 1);
    for (int i = 0; i < 2; i++) apply(1, 0, 45'h1ABCDEF0125B, 1);
    idle();
    rd(grp(2, O_VAL), 32'd3, "R6 mask/match over 45 bits");
    wr(grp(2, O_VAL), 0);
    wr(grp(2, O_CTL), 32'h7);
    for (int i = 0; i < 3; i++) apply(1, 0, 45'h1ABCDEF0125A, 1);
    for (int i = 0; i < 2; i++) apply(1, 0, 45'h0ABCDEF0125A, 1);
    for (int i = 0; i < 2; i++) apply(1, 0, 45'h1ABCDEF0125B, 1);
    for (int i = 0; i < 2; i++) apply(0, 0, 45'h0ABCDEF0125A, 1);
    idle();
    rd(grp(2, O_VAL), 32'd4, "R7 inverted filter, event still needed");
    wr(grp(2, O_CTL), 0);
  endtask

  task automatic t_incmode();
    logic pat1 [9] = '{1, 1, 0, 1, 0, 0, 1, 1, 1};
    wr(grp(3, O_CTL), 32'h85);
    for (int i = 0; i < 9; i++) apply({24'd0, pat1[i]}, 0, 0, 1);
    idle();
    rd(grp(3, O_VAL), 32'd3, "R8 mode 1 counts rising edges");
    wr(grp(3, O_CTL), 0);
    wr(grp(3, O_VAL), 0);
    wr(grp(3, O_CTL), 32'h105);
    for (int i = 0; i < 4; i++) apply({24'd0, pat1[i]}, 0, 0, 1);
    idle();
    rd(grp(3, O_VAL), 32'd3, "R8 mode 2 counts every qualified tick");
    wr(grp(3, O_CTL), 0);
  endtask

  task automatic t_halfrate();
    logic he [6] = '{1, 0, 1, 1, 0, 0};
    wr(grp(0, O_CTL), 32'h5);
    wr(grp(8, O_CTL), 32'h5);
    for (int i = 0; i < 6; i++) apply(1, 2'b01, 0, he[i]);
    idle();
    rd(grp(0, O_VAL), 32'd3, "R9 half group needs half_en");
    rd(grp(8, O_VAL), 32'd6, "R9 full group ignores half_en");
    wr(grp(0, O_CTL), 0);
    wr(grp(8, O_CTL), 0);
  endtask

  task automatic t_write_wins();
    wr(grp(5, O_CTL), 32'h5);
    apply(1, 0, 0, 1);
    wr(grp(5, O_VAL), 32'h100);
    evt_half = '0;
    idle();
    rd(grp(5, O_VAL), 32'h100, "R10 value write beats count");
    wr(grp(5, O_CTL), 0);
  endtask

  task automatic t_overflow();
    wr(grp(4, O_VAL), 32'hFFFFFFFE);
    wr(grp(4, O_CTL), 32'h5);
    apply(1, 0, 0, 1); idle();
    rd(grp(4, O_VAL), 32'hFFFFFFFF, "R11 one below wrap");
    rd(12'h8, 32'd0, "R11 no flag before wrap");
    chk_irq(1'b0, "R13 irq low before wrap");
    apply(1, 0, 0, 1); idle();
    rd(grp(4, O_VAL), 32'd0, "R11 wrapped to zero");
    rd(12'h8, 32'h10, "R11 half flag bit 4");
    chk_irq(1'b1, "R13 irq after wrap");
    wr(grp(4, O_CTL), 0);
    wr(grp(9, O_VAL), 32'hFFFFFFFF);
    wr(grp(9, O_CTL), 32'h5);
    apply(0, 2'b01, 0, 1); idle();
    rd(12'hC, 32'h2, "R11 full flag bit 1");
    wr(grp(9, O_CTL), 0);
    wr(12'hC, 32'hFFFFFFFF);
    rd(12'hC, 32'h2, "R12 ones keep flag");
    wr(12'h8, 32'hFFFFFFEF);
    rd(12'h8, 32'd0, "R12 zero bit clears");
    chk_irq(1'b1, "R13 irq held by full flag");
    wr(12'hC, 32'd0);
    rd(12'hC, 32'd0, "R12 write zero clears");
    chk_irq(1'b0, "R13 irq drops when flags clear");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_unmapped();
    t_evtsel();
    t_filter();
    t_incmode();
    t_halfrate();
    t_write_wins();
    t_overflow();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL R1 watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule